// File: doc/BRIEF.md
# CPU Doze Rate Gate

This block slows the processor while every peripheral keeps running at the system clock rate. It does not make a clock. It makes two single-cycle enables that are taken from one system clock. The peripheral enable is high on every cycle. The CPU enable is high on one cycle out of every 2^k cycles. Both enables always change on the same clock edges, so the peripherals and their register traffic keep full speed and stay aligned with the CPU.

Software programs the block through a register-style write port. The port carries a doze on/off bit, a 3-bit rate code `k` (ratio 1:2^k, from 1:1 up to 1:128) and a wake-on-interrupt bit. When wake-on-interrupt is set, an interrupt event clears the doze bit in hardware. The CPU then returns to full rate at once. When wake-on-interrupt is clear, interrupt events do not affect doze operation.

Top module: `cpu_doze_gate`

## Requirements
- R1: While `rst` is high, `cpu_ce`, `periph_ce` and `doze_on` are all 0. After reset, doze is off, the rate code is 0 and wake-on-interrupt is off, so `cpu_ce` is high on every cycle from the first clock edge after reset.
- R2: From the first clock edge after reset, `periph_ce` is 1 on every cycle, whatever the configuration or interrupt activity.
- R3: A cycle with `cfg_wr` high loads `cfg_doze`, `cfg_rate` and `cfg_wake`. `doze_on` shows the loaded doze bit from the next cycle onwards.
- R4: While doze is off, `cpu_ce` is 1 on every cycle, whatever rate code is stored.
- R5: While doze is on with rate code k (0 to 7), `cpu_ce` is a one-cycle pulse that repeats exactly every 2^k cycles. With k=0 it is high on every cycle.
- R6: Suppose a write changes the doze bit or the rate code at clock edge E. Then the next `cpu_ce` pulse that the new setting produces is high in the cycle that follows edge E+2^k. Until edge E, pulses keep the old timing.
- R7: Suppose wake-on-interrupt and doze are both on and `irq_evt` is sampled high at edge E with no write. Then `doze_on` falls after E, `cpu_ce` is high in the cycle right after E, and it stays high on every cycle after that.
- R8: While wake-on-interrupt is off, `irq_evt` does not change `doze_on` or the timing of the `cpu_ce` pulses.
- R9: If `cfg_wr` and `irq_evt` are sampled on the same edge, the write wins. The doze bit takes the written value.
- R10: A write that leaves the doze bit and the rate code unchanged does not restart the divider. The `cpu_ce` pulses keep their phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_doze | input | 1 | Doze on/off bit to write |
| cfg_rate | input | 3 | Rate code k to write; CPU ratio is 1:2^k |
| cfg_wake | input | 1 | Wake-on-interrupt bit to write |
| irq_evt | input | 1 | Interrupt event pulse |
| cpu_ce | output | 1 | CPU clock-enable strobe |
| periph_ce | output | 1 | Peripheral clock-enable, full rate |
| doze_on | output | 1 | Live value of the doze bit |

## Verification
The bench sweeps all eight rate codes and checks the exact pulse spacing. A divider with an off-by-one terminal count fails here because its pulses drift. It rewrites the configuration in the middle of a period. A design that did not restart would give a first pulse at the wrong edge. A design that restarted on an identical write would shift the phase. It drives interrupts with wake-on-interrupt both on and off, and it drives one interrupt on the same edge as a write. A wrong priority or a late wake strobe would lose the written doze bit or delay the first full-rate CPU cycle.

// File: rtl/cpu_doze_pkg.sv
package cpu_doze_pkg;
  localparam int RATE_W = 3;

  typedef struct packed {
    logic                doze;
    logic [RATE_W-1:0]   rate;
    logic                wake;
  } doze_cfg_t;
endpackage

// File: rtl/cpu_doze_cfg.sv
module cpu_doze_cfg
  import cpu_doze_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic                wr_doze,
  input  logic [RATE_W-1:0]   wr_rate,
  input  logic                wr_wake,
  input  logic                irq,
  output doze_cfg_t           cfg,
  output logic                wake_hit,
  output logic                restart
);
  doze_cfg_t cfg_q;
  logic      setting_moves;

  // hardware wake only when no write is competing (write has priority)
  assign wake_hit      = irq && cfg_q.wake && cfg_q.doze && !wr;
  assign setting_moves = wr && ((wr_doze != cfg_q.doze) || (wr_rate != cfg_q.rate));
  assign restart       = setting_moves || wake_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.doze <= 1'b0;
      cfg_q.rate <= '0;
      cfg_q.wake <= 1'b0;
    end else if (wr) begin
      cfg_q.doze <= wr_doze;
      cfg_q.rate <= wr_rate;
      cfg_q.wake <= wr_wake;
    end else if (wake_hit) begin
      cfg_q.doze <= 1'b0;
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/cpu_doze_div.sv
module cpu_doze_div #(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate,
  input  logic              restart,
  output logic              wrap
);
  localparam int CNT_W = (1 << RATE_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;

  // terminal count 2^rate - 1 as a thermometer of the rate code
  for (genvar i = 0; i < CNT_W; i++) begin : g_term
    assign term[i] = (32'(rate) > i);
  end

  assign wrap = (cnt_q == term);

  always_ff @(posedge clk) begin
    if (rst || restart || wrap) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cpu_doze_gate.sv
module cpu_doze_gate
  import cpu_doze_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_doze,
  input  logic [2:0]        cfg_rate,
  input  logic              cfg_wake,
  input  logic              irq_evt,
  output logic              cpu_ce,
  output logic              periph_ce,
  output logic              doze_on
);
  doze_cfg_t cfg_q;
  logic      wake_hit;
  logic      restart;
  logic      wrap;
  logic      cpu_ce_q;
  logic      periph_ce_q;

  cpu_doze_cfg u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr       (cfg_wr),
    .wr_doze  (cfg_doze),
    .wr_rate  (cfg_rate),
    .wr_wake  (cfg_wake),
    .irq      (irq_evt),
    .cfg      (cfg_q),
    .wake_hit (wake_hit),
    .restart  (restart)
  );

  cpu_doze_div #(.RATE_W(RATE_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .rate    (cfg_q.rate),
    .restart (restart),
    .wrap    (wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_ce_q    <= 1'b0;
      periph_ce_q <= 1'b0;
    end else begin
      cpu_ce_q    <= !cfg_q.doze || wrap || wake_hit;
      periph_ce_q <= 1'b1;
    end
  end

  assign cpu_ce    = cpu_ce_q;
  assign periph_ce = periph_ce_q;
  assign doze_on   = cfg_q.doze;
endmodule

// File: rtl/cpu_doze_checker.sv
module cpu_doze_checker (
  input logic clk,
  input logic rst,
  input logic cfg_wr,
  input logic cfg_doze,
  input logic irq_evt,
  input logic wake_q,
  input logic cpu_ce,
  input logic periph_ce,
  input logic doze_on
);
  p_periph_full_r2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> periph_ce);

  p_write_loads_r3: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> (doze_on == $past(cfg_doze)));

  p_full_rate_r4: assert property (@(posedge clk) disable iff (rst)
    !doze_on |=> cpu_ce);

  p_wake_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_evt && wake_q && doze_on && !cfg_wr) |=> (!doze_on && cpu_ce));

  p_no_wake_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_evt && !wake_q && !cfg_wr) |=> $stable(doze_on));
endmodule

bind cpu_doze_gate cpu_doze_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_wr    (cfg_wr),
  .cfg_doze  (cfg_doze),
  .irq_evt   (irq_evt),
  .wake_q    (cfg_q.wake),
  .cpu_ce    (cpu_ce),
  .periph_ce (periph_ce),
  .doze_on   (doze_on)
);

// File: tb/cpu_doze_gate_bench.sv
module cpu_doze_gate_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic       cfg_doze = 1'b0;
  logic [2:0] cfg_rate = 3'd0;
  logic       cfg_wake = 1'b0;
  logic       irq_evt = 1'b0;
  logic       cpu_ce, periph_ce, doze_on;

  int    errors = 0;
  int    checks = 0;
  int    cycles = 0;
  string cur_req = "R1";

  // reference model state
  int m_doze = 0, m_rate = 0, m_wake = 0, m_left = 1, m_ce = 0, m_pce = 0;

  always #2 clk = ~clk;

  cpu_doze_gate u_cpu_doze_gate (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_doze(cfg_doze),
    .cfg_rate(cfg_rate), .cfg_wake(cfg_wake), .irq_evt(irq_evt),
    .cpu_ce(cpu_ce), .periph_ce(periph_ce), .doze_on(doze_on)
  );

  // behavioural reference: m_left counts edges down to the next CPU strobe
  always @(posedge clk) begin
    if (rst) begin
      m_doze = 0; m_rate = 0; m_wake = 0; m_left = 1; m_ce = 0; m_pce = 0;
    end else begin
      bit woke, moved;
      int nd, nr;
      woke  = irq_evt && m_wake != 0 && m_doze != 0 && !cfg_wr;
      moved = cfg_wr && ((int'(cfg_doze) != m_doze) || (int'(cfg_rate) != m_rate));
      m_ce  = (m_doze == 0 || m_left == 1 || woke) ? 1 : 0;
      m_pce = 1;
      nd = m_doze; nr = m_rate;
      if (cfg_wr) begin
        nd = cfg_doze; nr = cfg_rate; m_wake = cfg_wake;
      end else if (woke) begin
        nd = 0;
      end
      if (moved || woke) m_left = 1 << nr;
      else if (m_left <= 1) m_left = 1 << m_rate;
      else m_left = m_left - 1;
      m_doze = nd; m_rate = nr;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst) begin
      check("R1", "cpu_ce in reset", cpu_ce, 0);
      check("R1", "periph_ce in reset", periph_ce, 0);
      check("R1", "doze_on in reset", doze_on, 0);
    end else begin
      check(cur_req, "cpu_ce", cpu_ce, m_ce);
      check("R2", "periph_ce", periph_ce, m_pce);
      check(cur_req, "doze_on", doze_on, m_doze);
    end
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit d, input int r, input bit w, input string tag, input bit with_irq);
    @(negedge clk); #1;
    cur_req = tag;
    cfg_wr = 1'b1; cfg_doze = d; cfg_rate = 3'(r); cfg_wake = w; irq_evt = with_irq;
    @(negedge clk); #1;
    cfg_wr = 1'b0; irq_evt = 1'b0;
  endtask

  task automatic irq_pulse(input string tag);
    @(negedge clk); #1;
    cur_req = tag; irq_evt = 1'b1;
    @(negedge clk); #1;
    irq_evt = 1'b0;
  endtask

  initial begin
    run(4);
    #1 rst = 1'b0;
    cur_req = "R1";
    run(8);
    // R4: doze off with a large code still gives full rate
    wr(1'b0, 5, 1'b0, "R4", 1'b0);
    run(12);
    // R3 / R5: every rate code
    for (int k = 0; k < 8; k++) begin
      wr(1'b1, k, 1'b0, "R5", 1'b0);
      run((2 << k) + 3);
    end
    // R6: change rate in the middle of a period
    wr(1'b1, 4, 1'b0, "R6", 1'b0);
    run(5);
    wr(1'b1, 2, 1'b0, "R6", 1'b0);
    run(14);
    // R10: identical rewrite keeps the phase
    wr(1'b1, 3, 1'b0, "R10", 1'b0);
    run(3);
    wr(1'b1, 3, 1'b1, "R10", 1'b0);
    run(20);
    // R7: wake on interrupt
    wr(1'b1, 4, 1'b1, "R7", 1'b0);
    run(6);
    irq_pulse("R7");
    @(negedge clk);
    check("R7", "doze_on after wake irq", doze_on, 0);
    check("R7", "cpu_ce after wake irq", cpu_ce, 1);
    run(6);
    // R8: interrupt ignored without wake
    wr(1'b1, 3, 1'b0, "R8", 1'b0);
    run(5);
    irq_pulse("R8");
    run(3);
    irq_pulse("R8");
    @(negedge clk);
    check("R8", "doze_on kept", doze_on, 1);
    run(12);
    // R9: write and interrupt on the same edge
    wr(1'b1, 2, 1'b1, "R9", 1'b0);
    run(3);
    wr(1'b1, 6, 1'b1, "R9", 1'b1);
    @(negedge clk);
    check("R9", "doze_on kept by write", doze_on, 1);
    run(70);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule